// File: doc/BRIEF.md
# Transparent Address Window Checker

This block decides, for each access of one access stream, whether the logical address lands inside one of two programmable windows that bypass page translation. Each window names a base value and a don't-care mask over the eight most significant address bits, so one window spans anything from a 16 MB region up to the whole 4 GB space. When an access lands in an enabled window, the logical address is handed on unchanged as the physical address. The translation cache is told to stand aside through a bypass output. The winning window's protection and cache-mode attributes are applied.

Software configures the windows through a simple register write port that selects one window at a time. The lookup port takes an address, a supervisor flag and a write flag. It returns a registered result one clock later: hit, fault, pass-through address, cache mode, the index of the winning window and the bypass indication. Only one access stream is served. A second stream uses a second instance.

Top module: `tt_range_check`

## Requirements
- R1: After reset, every window is disabled and no result is valid; a lookup issued before any configuration write returns a miss.
- R2: A lookup presented with `lk_valid` high at a rising clock edge produces `rs_valid` high during the following cycle. A cycle with `lk_valid` low produces `rs_valid` low in the next cycle.
- R3: A window matches when, for every address bit 31..24 whose mask bit is 0, the address bit equals the corresponding base bit. Address bits whose mask bit is 1 are ignored.
- R4: A window whose enable bit is 0 never matches, whatever its base, mask and the access.
- R5: On a hit, `rs_paddr` equals the logical address of the lookup in all 32 bits. On a miss, `rs_paddr` is zero. `rs_bypass` is high exactly when the result is a hit without a fault.
- R6: The mode filter field selects which accesses may match: 00 or 11 means any access, 01 means only accesses with `lk_super` low, and 10 means only accesses with `lk_super` high.
- R7: A write (`lk_write` high) that hits a window whose write-protect bit is 1 gives `rs_fault` high. A read to the same window, or a write to an unprotected window, gives no fault.
- R8: When both windows match, window 0 wins. `rs_win`, `rs_cmode` and the fault decision all come from window 0.
- R9: The configuration word is laid out as base in bits 7:0, mask in bits 15:8, enable in bit 16, mode filter in bits 18:17, write-protect in bit 19 and cache mode in bits 21:20. A write with `cfg_we` high updates window `cfg_idx` at the clock edge. A lookup issued at that same edge still sees the old setting, and later lookups see the new one.
- R10: On a hit, `rs_cmode` carries the winning window's cache-mode field. On a miss, `rs_cmode`, `rs_win` and `rs_fault` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 1 | Window selected for the write |
| cfg_data | input | 22 | Configuration word (layout in R9) |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Logical address |
| lk_super | input | 1 | Access made in supervisor mode |
| lk_write | input | 1 | Access is a write |
| rs_valid | output | 1 | Result valid, one cycle after the request |
| rs_hit | output | 1 | Address fell in an enabled, permitted window |
| rs_bypass | output | 1 | Translation cache may be skipped |
| rs_fault | output | 1 | Write-protect violation |
| rs_paddr | output | 32 | Physical address (pass-through on hit) |
| rs_cmode | output | 2 | Cache mode of the winning window |
| rs_win | output | 1 | Index of the winning window |

## Verification
A corrupted window register surfaces at the ports on the very next lookup that touches its address range. It appears as a missing or spurious hit, a wrong cache mode or a wrong fault. It therefore shows up one cycle after such a lookup and never earlier. A wrong priority choice only shows when both windows overlap, so the stimulus places one window inside another and varies the access mode and direction across that overlap. Misrouting of the result register shows up as a pass-through address that differs from the request issued one cycle before.

// File: rtl/tt_pkg.sv
package tt_pkg;
    localparam int TT_CMPW = 8;
    localparam int TT_CFGW = 22;

    typedef enum logic [1:0] {
        MODE_ANY   = 2'b00,
        MODE_USER  = 2'b01,
        MODE_SUPER = 2'b10,
        MODE_ANY2  = 2'b11
    } tt_mode_e;

    typedef struct packed {
        logic [1:0]         cmode;
        logic               wprot;
        tt_mode_e           mode;
        logic               en;
        logic [TT_CMPW-1:0] mask;
        logic [TT_CMPW-1:0] base;
    } tt_win_t;
endpackage

// File: rtl/tt_win_reg.sv
module tt_win_reg
    import tt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [TT_CFGW-1:0] wdata,
    output tt_win_t            cfg
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (we) begin
            cfg <= tt_win_t'(wdata);
        end
    end
endmodule

// File: rtl/tt_win_match.sv
module tt_win_match
    import tt_pkg::*;
(
    input  tt_win_t            cfg,
    input  logic [TT_CMPW-1:0] addr_hi,
    input  logic               super_acc,
    output logic               hit
);
    logic mode_ok;
    logic addr_ok;

    always_comb begin
        unique case (cfg.mode)
            MODE_USER:  mode_ok = !super_acc;
            MODE_SUPER: mode_ok = super_acc;
            default:    mode_ok = 1'b1;
        endcase
        addr_ok = (((addr_hi ^ cfg.base) & ~cfg.mask) == '0);
        hit     = cfg.en && mode_ok && addr_ok;
    end
endmodule

// File: rtl/tt_pick.sv
module tt_pick #(
    parameter int NWIN = 2,
    localparam int IW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic [NWIN-1:0] hits,
    output logic            any,
    output logic [IW-1:0]   idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/tt_range_check.sv
module tt_range_check
    import tt_pkg::*;
#(
    parameter int NWIN = 2,
    parameter int AW   = 32,
    localparam int IW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [IW-1:0]      cfg_idx,
    input  logic [TT_CFGW-1:0] cfg_data,
    input  logic               lk_valid,
    input  logic [AW-1:0]      lk_addr,
    input  logic               lk_super,
    input  logic               lk_write,
    output logic               rs_valid,
    output logic               rs_hit,
    output logic               rs_bypass,
    output logic               rs_fault,
    output logic [AW-1:0]      rs_paddr,
    output logic [1:0]         rs_cmode,
    output logic [IW-1:0]      rs_win
);
    tt_win_t          cfg [NWIN];
    logic [NWIN-1:0]  hits;
    logic             any_hit;
    logic [IW-1:0]    win_idx;
    tt_win_t          win_cfg;
    logic             fault_d;

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        tt_win_reg u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (cfg_we && (cfg_idx == IW'(g))),
            .wdata (cfg_data),
            .cfg   (cfg[g])
        );
        tt_win_match u_match (
            .cfg       (cfg[g]),
            .addr_hi   (lk_addr[AW-1 -: TT_CMPW]),
            .super_acc (lk_super),
            .hit       (hits[g])
        );
    end

    tt_pick #(.NWIN(NWIN)) u_pick (
        .hits (hits),
        .any  (any_hit),
        .idx  (win_idx)
    );

    always_comb begin
        win_cfg = cfg[win_idx];
        fault_d = any_hit && lk_write && win_cfg.wprot;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_valid  <= 1'b0;
            rs_hit    <= 1'b0;
            rs_bypass <= 1'b0;
            rs_fault  <= 1'b0;
            rs_paddr  <= '0;
            rs_cmode  <= '0;
            rs_win    <= '0;
        end else begin
            rs_valid  <= lk_valid;
            rs_hit    <= lk_valid && any_hit;
            rs_bypass <= lk_valid && any_hit && !fault_d;
            rs_fault  <= lk_valid && fault_d;
            rs_paddr  <= (lk_valid && any_hit) ? lk_addr : '0;
            rs_cmode  <= (lk_valid && any_hit) ? win_cfg.cmode : 2'b00;
            rs_win    <= (lk_valid && any_hit) ? win_idx : '0;
        end
    end
endmodule

// File: rtl/tt_range_check_chk.sv
module tt_range_check_chk #(
    parameter int AW = 32,
    parameter int IW = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lk_valid,
    input logic [AW-1:0] lk_addr,
    input logic          lk_write,
    input logic          rs_valid,
    input logic          rs_hit,
    input logic          rs_bypass,
    input logic          rs_fault,
    input logic [AW-1:0] rs_paddr,
    input logic [1:0]    rs_cmode,
    input logic [IW-1:0] rs_win
);
    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rs_valid); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rs_valid && !rs_hit); // R2
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!rs_hit || rs_paddr == $past(lk_addr))); // R5
    AST_BYPASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        rs_bypass |-> rs_hit && !rs_fault); // R5
    AST_FAULT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && !lk_write |=> !rs_fault); // R7
    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_hit |-> rs_cmode == 2'b00 && rs_win == '0 && !rs_fault && rs_paddr == '0); // R10
endmodule

bind tt_range_check tt_range_check_chk #(.AW(AW), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_addr   (lk_addr),
    .lk_write  (lk_write),
    .rs_valid  (rs_valid),
    .rs_hit    (rs_hit),
    .rs_bypass (rs_bypass),
    .rs_fault  (rs_fault),
    .rs_paddr  (rs_paddr),
    .rs_cmode  (rs_cmode),
    .rs_win    (rs_win)
);

// File: tb/sim_tt_range_check.sv
module sim_tt_range_check;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [0:0]  cfg_idx = '0;
    logic [21:0] cfg_data = '0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        lk_super = 1'b0;
    logic        lk_write = 1'b0;
    logic        rs_valid, rs_hit, rs_bypass, rs_fault;
    logic [31:0] rs_paddr;
    logic [1:0]  rs_cmode;
    logic [0:0]  rs_win;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tt_range_check u0 (.*);

    typedef struct {
        string       tag;
        logic        hit;
        logic        byp;
        logic        flt;
        logic [31:0] pa;
        logic [1:0]  cm;
        logic [0:0]  win;
    } exp_t;

    exp_t sb[$];

    logic [7:0] sh_base [2];
    logic [7:0] sh_mask [2];
    logic       sh_en   [2];
    logic [1:0] sh_mode [2];
    logic       sh_wp   [2];
    logic [1:0] sh_cm   [2];

    function automatic exp_t model(input logic [31:0] a, input logic s, input logic w, input string tag);
        exp_t e;
        e.tag = tag; e.hit = 0; e.byp = 0; e.flt = 0; e.pa = 0; e.cm = 0; e.win = 0;
        for (int i = 1; i >= 0; i--) begin
            logic ok;
            ok = sh_en[i];
            for (int b = 0; b < 8; b++)
                if (!sh_mask[i][b] && (a[24+b] != sh_base[i][b])) ok = 0;
            if (sh_mode[i] == 2'b01 && s) ok = 0;
            if (sh_mode[i] == 2'b10 && !s) ok = 0;
            if (ok) begin
                e.hit = 1; e.pa = a; e.cm = sh_cm[i]; e.win = 1'(i);
                e.flt = w && sh_wp[i];
            end
        end
        e.byp = e.hit && !e.flt;
        return e;
    endfunction

    task automatic stage_cfg(input int i, input logic [7:0] b, input logic [7:0] m, input logic en,
                             input logic [1:0] md, input logic wp, input logic [1:0] cm);
        cfg_we = 1; cfg_idx = 1'(i);
        cfg_data = {cm, wp, md, en, m, b};
    endtask

    task automatic commit_cfg(input int i);
        sh_base[i] = cfg_data[7:0];  sh_mask[i] = cfg_data[15:8];
        sh_en[i]   = cfg_data[16];   sh_mode[i] = cfg_data[18:17];
        sh_wp[i]   = cfg_data[19];   sh_cm[i]   = cfg_data[21:20];
    endtask

    task automatic write_cfg(input int i, input logic [7:0] b, input logic [7:0] m, input logic en,
                             input logic [1:0] md, input logic wp, input logic [1:0] cm);
        stage_cfg(i, b, m, en, md, wp, cm);
        @(posedge clk); #1;
        commit_cfg(i);
        cfg_we = 0;
    endtask

    task automatic look(input logic [31:0] a, input logic s, input logic w, input string tag);
        lk_valid = 1; lk_addr = a; lk_super = s; lk_write = w;
        sb.push_back(model(a, s, w, tag));
        @(posedge clk); #1;
        lk_valid = 0;
    endtask

    task automatic check(input string tag, input bit ok, input string what);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && rs_valid) begin
            if (sb.size() == 0) begin
                check("R2", 0, "result with nothing expected (actual valid=1 expected 0)");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, rs_hit == e.hit && rs_bypass == e.byp && rs_fault == e.flt &&
                      rs_paddr == e.pa && rs_cmode == e.cm && rs_win == e.win,
                      $sformatf("actual hit=%b byp=%b flt=%b pa=%h cm=%0d win=%0d expected hit=%b byp=%b flt=%b pa=%h cm=%0d win=%0d",
                                rs_hit, rs_bypass, rs_fault, rs_paddr, rs_cmode, rs_win,
                                e.hit, e.byp, e.flt, e.pa, e.cm, e.win));
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        check("WATCHDOG", 0, "run did not end (actual hung, expected done)");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            sh_base[i] = 0; sh_mask[i] = 0; sh_en[i] = 0;
            sh_mode[i] = 0; sh_wp[i] = 0; sh_cm[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check("R1", rs_valid == 0 && rs_hit == 0,
              $sformatf("after reset actual valid=%b hit=%b expected 0 0", rs_valid, rs_hit));
        @(posedge clk); #1;
        look(32'h0000_1000, 0, 0, "R1");
        // idle cycle: no result expected (R2)
        @(posedge clk); #1;
        @(negedge clk);
        check("R2", rs_valid == 0, $sformatf("idle actual valid=%b expected 0", rs_valid));

        // R4: disabled window with catch-all mask stays silent
        write_cfg(0, 8'h00, 8'hFF, 0, 2'b00, 0, 2'd3);
        look(32'h1234_5678, 0, 0, "R4");

        // R3, R9: window 0 covers 0x40..0x4F, cache mode 2
        write_cfg(0, 8'h40, 8'h0F, 1, 2'b00, 0, 2'd2);
        look(32'h4A00_0010, 0, 0, "R3");
        look(32'h5000_0000, 0, 0, "R3");
        look(32'h4FFF_FFFC, 1, 1, "R5");
        look(32'h3FFF_FFFF, 1, 0, "R10");

        // R6: window 1 user-only at 0x80 exact, write protected, cache mode 1
        write_cfg(1, 8'h80, 8'h00, 1, 2'b01, 1, 2'd1);
        look(32'h8000_0004, 0, 0, "R6");
        look(32'h8000_0004, 1, 0, "R6");
        look(32'h80FF_0000, 0, 1, "R7");
        look(32'h8100_0000, 0, 0, "R3");

        // R6: supervisor-only, and mode 11 behaves as any
        write_cfg(1, 8'h80, 8'h00, 1, 2'b10, 0, 2'd1);
        look(32'h8000_0000, 0, 0, "R6");
        look(32'h8000_0000, 1, 1, "R6");
        write_cfg(1, 8'h80, 8'h00, 1, 2'b11, 0, 2'd1);
        look(32'h8000_0000, 0, 0, "R6");

        // R8: window 1 covers all, protected; window 0 inside it, not protected
        write_cfg(1, 8'h00, 8'hFF, 1, 2'b00, 1, 2'd3);
        look(32'h4400_0000, 0, 1, "R8");
        look(32'h9000_0000, 0, 1, "R7");
        look(32'h9000_0000, 1, 0, "R7");
        write_cfg(0, 8'h40, 8'h0F, 1, 2'b00, 1, 2'd2);
        look(32'h4400_0000, 0, 1, "R8");

        // R9: write and lookup at the same edge see the old setting
        stage_cfg(0, 8'h40, 8'h0F, 0, 2'b00, 0, 2'd2);
        lk_valid = 1; lk_addr = 32'h4100_0000; lk_super = 0; lk_write = 0;
        sb.push_back(model(32'h4100_0000, 0, 0, "R9"));
        @(posedge clk); #1;
        commit_cfg(0);
        cfg_we = 0;
        look(32'h4100_0000, 0, 0, "R9");

        repeat (3) @(posedge clk);
        check("R2", sb.size() == 0, $sformatf("pending results actual %0d expected 0", sb.size()));
        finish_run();
    end
endmodule